// File: doc/BRIEF.md
# Sectioned GPIO Controller with Interrupt Capture

This block controls 32 general-purpose pins arranged as four identical sections of eight. Each section owns a 64-byte register window on a simple single-cycle register bus. Through that window software sets the drive direction and output value of each pin, reads the synchronized pin levels, and manages per-pin interrupts. Each pin can be set to edge or level sensitivity, and its interrupt can be masked with separate set-mask and clear-mask strobes. The block drives output values and output enables towards the pads, samples the pad inputs through a two-flop synchronizer, and raises one interrupt line for the whole controller.

The bus has no handshake and no back-pressure. A read returns data combinationally from the address in the same cycle. A write is accepted on every clock edge where the write enable is high and takes effect at that edge. Pin n belongs to section n>>3, bit n&7. The section is selected by address bits [7:6], and the register within the section by bits [5:0].

Top module: `gpio_sec_ctrl`

## Requirements
- R1: After reset every direction bit is 1 (all `pin_oe` low), all output latches are 0, all mask bits are 1, all mode bits are 0 (edge), all status bits are 0, and `irq` is low.
- R2: Address bits [7:6] select the section and bits [5:0] select the register. The registers are 0x00 masked status (read-only), 0x04 raw status, 0x08 mask (read) / clear-mask strobe (write), 0x0C set-mask strobe (write-only, reads 0), 0x10 direction, 0x14 output latch, 0x18 synchronized input (read-only), and 0x20 mode. Any other offset reads 0 and ignores writes. Data bits [7:0] carry pins 0..7 of the section, and the upper read bits are 0.
- R3: A direction bit of 1 makes the pin an input and 0 makes it an output. `pin_oe` is the inverse of the direction bit, and `pin_out` carries the output latch.
- R4: Pin inputs pass through a two-flop synchronizer. A change at `pin_in` shows at offset 0x18 after two rising clock edges and not after one.
- R5: With mode bit 0 (edge), a rising edge of the synchronized input sets the status bit, and the bit stays set after the input falls. A pin held high does not set the bit again after it is cleared.
- R6: With mode bit 1 (level, written at offset 0x20 with plain write semantics), the status bit is set on every cycle the synchronized input is high. A clear issued while the input is high leaves the bit set.
- R7: Writing ones to offset 0x04 clears those status bits, and bits written as 0 are unchanged. A clear and a new event on the same bit at the same edge leaves the bit set.
- R8: Writing ones to 0x0C sets the corresponding mask bits. Writing ones to 0x08 clears them. Bits written as 0 leave the mask unchanged in both cases, and reading 0x08 returns the mask.
- R9: The masked status at offset 0x00 equals status AND NOT mask. `irq` is the OR of the masked status of all sections. Masking never changes the raw status.
- R10: Read data follows the address in the same cycle, and a write is visible to a read in the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address: section in [7:6], register in [5:0] |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | 32 | Write data, bits [7:0] used |
| bus_rdata | output | 32 | Combinational read data, bits [31:8] zero |
| pin_in | input | 32 | Raw pad input levels |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Output enables, 1 drives the pad |
| irq | output | 1 | OR of all unmasked pending interrupts |

## Verification
The interrupt path is tested with a single pin rising once, a pin held high across a clear, and a pin in level mode cleared while high and again after it falls. Together these separate sticky edge capture from level following. Two pins of one section are raised together and only one is cleared, which shows that a clear touches only the bits written as 1. A clear timed to land on the same edge as a new event shows which of the two wins. Each section is driven with a distinct byte pattern (0x81, 0x00, 0x3C, 0xA5), so a swapped section or bit order is visible. The read-back is taken one edge and two edges after the change, which pins down the synchronizer depth.

// File: rtl/gpio_sec_pkg.sv
package gpio_sec_pkg;
  // Byte offset width of one section window
  localparam int WIN_BITS = 6;

  // Register offsets inside a section window
  typedef enum logic [WIN_BITS-1:0] {
    REG_MSTAT   = 6'h00,  // status & ~mask, read-only
    REG_STAT    = 6'h04,  // raw status, write-one-to-clear
    REG_MASK    = 6'h08,  // read mask, write ones to unmask
    REG_MASKSET = 6'h0C,  // write ones to mask, reads zero
    REG_DIR     = 6'h10,  // 1 = input
    REG_OUT     = 6'h14,  // output latch
    REG_IN      = 6'h18,  // synchronized input, read-only
    REG_MODE    = 6'h20   // 1 = level, 0 = edge
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_section.sv
module gpio_section
  import gpio_sec_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_we,
  input  logic [WIN_BITS-1:0] off,
  input  logic [PINS-1:0]     wdata,
  output logic [PINS-1:0]     rdata,
  input  logic [PINS-1:0]     pin_sync,
  output logic [PINS-1:0]     dir_q,
  output logic [PINS-1:0]     out_q,
  output logic [PINS-1:0]     mask_q,
  output logic [PINS-1:0]     status_q,
  output logic [PINS-1:0]     masked
);
  logic [PINS-1:0] mode_q;
  logic [PINS-1:0] prev_q;
  logic [PINS-1:0] rise;
  logic [PINS-1:0] event_v;
  logic [PINS-1:0] clr_v;

  assign rise    = pin_sync & ~prev_q;
  assign event_v = (mode_q & pin_sync) | (~mode_q & rise);
  assign clr_v   = (sel_we && off == REG_STAT) ? wdata : '0;
  assign masked  = status_q & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '1;
      out_q    <= '0;
      mask_q   <= '1;
      mode_q   <= '0;
      status_q <= '0;
      prev_q   <= '0;
    end else begin
      prev_q   <= pin_sync;
      // a new event wins over a clear of the same bit
      status_q <= (status_q & ~clr_v) | event_v;
      if (sel_we) begin
        case (off)
          REG_MASK:    mask_q <= mask_q & ~wdata;
          REG_MASKSET: mask_q <= mask_q | wdata;
          REG_DIR:     dir_q  <= wdata;
          REG_OUT:     out_q  <= wdata;
          REG_MODE:    mode_q <= wdata;
          default:     ;
        endcase
      end
    end
  end

  always_comb begin
    case (off)
      REG_MSTAT: rdata = masked;
      REG_STAT:  rdata = status_q;
      REG_MASK:  rdata = mask_q;
      REG_DIR:   rdata = dir_q;
      REG_OUT:   rdata = out_q;
      REG_IN:    rdata = pin_sync;
      REG_MODE:  rdata = mode_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_sec_ctrl.sv
module gpio_sec_ctrl
  import gpio_sec_pkg::*;
#(
  parameter int SEC_COUNT   = 4,
  parameter int SEC_PINS    = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  localparam int NPINS  = SEC_COUNT * SEC_PINS,
  localparam int SEL_W  = (SEC_COUNT > 1) ? $clog2(SEC_COUNT) : 1,
  localparam int ADDR_W = WIN_BITS + SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);
  logic [SEL_W-1:0]    sel_idx;
  logic [WIN_BITS-1:0] off;
  logic [NPINS-1:0]    pin_sync;
  logic                unused_wdata;

  logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_dir;
  logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_out;
  logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_mask;
  logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_status;
  logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_masked;
  logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_rdata;

  assign sel_idx      = bus_addr[ADDR_W-1:WIN_BITS];
  assign off          = bus_addr[WIN_BITS-1:0];
  assign unused_wdata = ^bus_wdata;

  gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pin_sync)
  );

  for (genvar s = 0; s < SEC_COUNT; s++) begin : g_sec
    gpio_section #(.PINS(SEC_PINS)) u_sec (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_we   (bus_we && sel_idx == SEL_W'(s)),
      .off      (off),
      .wdata    (bus_wdata[SEC_PINS-1:0]),
      .rdata    (sec_rdata[s]),
      .pin_sync (pin_sync[s*SEC_PINS +: SEC_PINS]),
      .dir_q    (sec_dir[s]),
      .out_q    (sec_out[s]),
      .mask_q   (sec_mask[s]),
      .status_q (sec_status[s]),
      .masked   (sec_masked[s])
    );
    assign pin_oe[s*SEC_PINS +: SEC_PINS]  = ~sec_dir[s];
    assign pin_out[s*SEC_PINS +: SEC_PINS] = sec_out[s];
  end

  always_comb begin
    bus_rdata = '0;
    if (int'(sel_idx) < SEC_COUNT) begin
      bus_rdata[SEC_PINS-1:0] = sec_rdata[sel_idx];
    end
  end

  assign irq = |sec_masked;
endmodule

// File: rtl/gpio_sec_ctrl_chk.sv
module gpio_sec_ctrl_chk
  import gpio_sec_pkg::*;
#(
  parameter int SEC_COUNT = 4,
  parameter int SEC_PINS  = 8,
  parameter int DATA_W    = 32,
  localparam int NPINS  = SEC_COUNT * SEC_PINS,
  localparam int SEL_W  = (SEC_COUNT > 1) ? $clog2(SEC_COUNT) : 1,
  localparam int ADDR_W = WIN_BITS + SEL_W
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [ADDR_W-1:0]                  bus_addr,
  input logic                               bus_we,
  input logic [DATA_W-1:0]                  bus_wdata,
  input logic [DATA_W-1:0]                  bus_rdata,
  input logic [NPINS-1:0]                   pin_oe,
  input logic                               irq,
  input logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_mask,
  input logic [SEC_COUNT-1:0][SEC_PINS-1:0] sec_status
);
  logic [SEL_W-1:0]    sel;
  logic [WIN_BITS-1:0] off;
  logic [SEC_PINS-1:0] wd;
  logic                sel_ok;
  logic                unused_hi;
  logic [SEC_COUNT-1:0][SEC_PINS-1:0] clr_v;

  assign sel       = bus_addr[ADDR_W-1:WIN_BITS];
  assign off       = bus_addr[WIN_BITS-1:0];
  assign wd        = bus_wdata[SEC_PINS-1:0];
  assign sel_ok    = int'(sel) < SEC_COUNT;
  assign unused_hi = ^bus_wdata;

  always_comb begin
    for (int s = 0; s < SEC_COUNT; s++) begin
      clr_v[s] = (bus_we && off == REG_STAT && sel == SEL_W'(s)) ? wd : '0;
    end
  end

  AST_UNUSED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(off inside {REG_MSTAT, REG_STAT, REG_MASK, REG_DIR, REG_OUT, REG_IN, REG_MODE})
      |-> bus_rdata == '0);  // R2

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_ok && off == REG_DIR)
      |=> pin_oe[$past(sel)*SEC_PINS +: SEC_PINS] == ~$past(wd));  // R3

  AST_MASKSET_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_ok && off == REG_MASKSET)
      |=> (sec_mask[$past(sel)] & $past(wd)) == $past(wd));  // R8

  AST_UNMASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_ok && off == REG_MASK)
      |=> (sec_mask[$past(sel)] & $past(wd)) == '0);  // R8

  AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((sec_status & ~sec_mask) != '0));  // R9

  for (genvar s = 0; s < SEC_COUNT; s++) begin : g_sticky
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sec_status[s]) & ~sec_status[s] & ~$past(clr_v[s])) == '0);  // R7
  end
endmodule

bind gpio_sec_ctrl gpio_sec_ctrl_chk #(
  .SEC_COUNT (SEC_COUNT),
  .SEC_PINS  (SEC_PINS),
  .DATA_W    (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_oe     (pin_oe),
  .irq        (irq),
  .sec_mask   (sec_mask),
  .sec_status (sec_status)
);

// File: tb/gpio_sec_ctrl_test.sv
module gpio_sec_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic        irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_sec_ctrl uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_we    (we),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next one
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr  = a;
    wdata = {24'h0, d};
    we    = 1'b1;
    @(negedge clk);
    we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1", "pin_oe", pin_oe, 32'h0);
    chk("R1", "pin_out", pin_out, 32'h0);
    chk("R1", "irq", {31'h0, irq}, 32'h0);
    rd(8'h08, v); chk("R1", "mask sec0", v, 32'hFF);
    rd(8'hC8, v); chk("R1", "mask sec3", v, 32'hFF);
    rd(8'h10, v); chk("R1", "dir sec0", v, 32'hFF);
    rd(8'h60, v); chk("R1", "mode sec1", v, 32'h0);
    rd(8'h84, v); chk("R1", "status sec2", v, 32'h0);
  endtask

  task automatic t_dir_out;
    logic [31:0] v;
    wr(8'h50, 8'hF0);
    wr(8'h54, 8'h5A);
    chk("R3", "pin_oe", pin_oe, 32'h0000_0F00);
    chk("R3", "pin_out", pin_out, 32'h0000_5A00);
    rd(8'h54, v); chk("R10", "out readback next cycle", v, 32'h5A);
    rd(8'h14, v); chk("R2", "out sec0 untouched", v, 32'h0);
    rd(8'h50, v); chk("R2", "dir sec1 readback", v, 32'hF0);
  endtask

  task automatic t_unused;
    logic [31:0] v;
    wr(8'h1C, 8'hFF);
    wr(8'h24, 8'hFF);
    wr(8'h3F, 8'h01);
    rd(8'h1C, v); chk("R2", "offset 0x1C", v, 32'h0);
    rd(8'h24, v); chk("R2", "offset 0x24", v, 32'h0);
    rd(8'h0C, v); chk("R2", "mask-set reads zero", v, 32'h0);
    rd(8'h20, v); chk("R2", "mode untouched", v, 32'h0);
    rd(8'h08, v); chk("R2", "mask untouched", v, 32'hFF);
  endtask

  task automatic t_edge;  // pin 19 = section 2 bit 3
    logic [31:0] v;
    wr(8'h88, 8'h08);
    pin_in[19] = 1'b1;
    idle(4);
    rd(8'h84, v); chk("R5", "edge captured", v, 32'h08);
    chk("R9", "irq after edge", {31'h0, irq}, 32'h1);
    rd(8'h80, v); chk("R9", "masked status", v, 32'h08);
    pin_in[19] = 1'b0;
    idle(4);
    rd(8'h84, v); chk("R5", "sticky after fall", v, 32'h08);
    wr(8'h84, 8'h08);
    rd(8'h84, v); chk("R7", "cleared", v, 32'h0);
    chk("R9", "irq after clear", {31'h0, irq}, 32'h0);
    pin_in[19] = 1'b1;
    idle(4);
    wr(8'h84, 8'h08);
    idle(4);
    rd(8'h84, v); chk("R5", "held high no retrigger", v, 32'h0);
    pin_in[19] = 1'b0;
    idle(4);
    wr(8'h8C, 8'hFF);
  endtask

  task automatic t_level;  // pin 0
    logic [31:0] v;
    wr(8'h20, 8'h01);
    rd(8'h20, v); chk("R6", "mode readback", v, 32'h01);
    wr(8'h08, 8'h01);
    pin_in[0] = 1'b1;
    idle(4);
    rd(8'h04, v); chk("R6", "level status", v, 32'h01);
    wr(8'h04, 8'h01);
    rd(8'h04, v); chk("R6", "clear while high", v, 32'h01);
    chk("R6", "irq while high", {31'h0, irq}, 32'h1);
    pin_in[0] = 1'b0;
    idle(4);
    wr(8'h04, 8'h01);
    rd(8'h04, v); chk("R6", "clear after low", v, 32'h0);
    chk("R6", "irq after low", {31'h0, irq}, 32'h0);
    wr(8'h20, 8'h00);
    wr(8'h0C, 8'h01);
  endtask

  task automatic t_mask;  // pin 9 = section 1 bit 1
    logic [31:0] v;
    pin_in[9] = 1'b1;
    idle(4);
    rd(8'h44, v); chk("R9", "raw status while masked", v, 32'h02);
    rd(8'h40, v); chk("R9", "masked view", v, 32'h0);
    chk("R9", "irq masked", {31'h0, irq}, 32'h0);
    wr(8'h48, 8'h02);
    rd(8'h48, v); chk("R8", "unmask one bit", v, 32'hFD);
    chk("R9", "irq unmasked", {31'h0, irq}, 32'h1);
    wr(8'h48, 8'h00);
    rd(8'h48, v); chk("R8", "zero write keeps mask", v, 32'hFD);
    wr(8'h4C, 8'h02);
    rd(8'h48, v); chk("R8", "mask again", v, 32'hFF);
    chk("R9", "irq remasked", {31'h0, irq}, 32'h0);
    rd(8'h44, v); chk("R9", "raw status kept", v, 32'h02);
    pin_in[9] = 1'b0;
    idle(3);
    wr(8'h44, 8'hFF);
  endtask

  task automatic t_w1c;  // pins 24, 25 = section 3 bits 0, 1
    logic [31:0] v;
    pin_in[25:24] = 2'b11;
    idle(4);
    rd(8'hC4, v); chk("R7", "two bits set", v, 32'h03);
    wr(8'hC4, 8'h02);
    rd(8'hC4, v); chk("R7", "partial clear", v, 32'h01);
    pin_in[25:24] = 2'b00;
    idle(3);
    wr(8'hC4, 8'hFF);
    rd(8'hC4, v); chk("R7", "all cleared", v, 32'h0);
    // rise lands on the third edge from here; clear it on that same edge
    pin_in[24] = 1'b1;
    idle(2);
    wr(8'hC4, 8'h01);
    rd(8'hC4, v); chk("R7", "event beats clear", v, 32'h01);
    pin_in[24] = 1'b0;
    idle(3);
    wr(8'hC4, 8'hFF);
  endtask

  task automatic t_input;
    logic [31:0] v;
    pin_in = 32'hA53C_0081;
    idle(1);
    rd(8'hD8, v); chk("R4", "after one edge", v, 32'h0);
    idle(1);
    rd(8'hD8, v); chk("R4", "sec3 after two edges", v, 32'hA5);
    rd(8'h98, v); chk("R4", "sec2 input", v, 32'h3C);
    rd(8'h58, v); chk("R4", "sec1 input", v, 32'h00);
    rd(8'h18, v); chk("R4", "sec0 input", v, 32'h81);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_dir_out();
    t_unused();
    t_edge();
    t_level();
    t_mask();
    t_w1c();
    t_input();
    finish_up();
  end
endmodule